// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the arithmetic core of a small 8-bit processor. It holds an accumulator register and a status flag register. Each executed operation takes the accumulator as its first operand and a temporary operand from the caller as its second. It writes the result back into the accumulator and refreshes five status flags from that result. A caller that needs 16-bit arithmetic issues two 8-bit operations, low byte first, and feeds the carry flag back through the carry input.

The operation set covers add, add with carry, subtract, subtract with borrow, compare, AND, OR, XOR, increment and decrement. A single adder serves every arithmetic operation. The carry out of bit 3 is captured as the auxiliary (half) carry used for decimal adjustment, and the parity flag reports an even count of ones. Both registers change only on a clock edge where the execute strobe is high and the operation code is one the block defines.

Top module: `alu8_core`

## Requirements
- R1: A synchronous active-high reset sets the accumulator to 0x00 and the flag byte to 0x02.
- R2: The accumulator and the flag byte change only on a rising edge where exec_en is 1 and op_sel holds a defined code (0 to 9). Codes 10 to 15 and cycles with exec_en low leave both unchanged.
- R3: The operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 increment, 9 decrement. Add writes (A + T) mod 256 and add with carry writes (A + T + cy_in) mod 256. For both, CY is the carry out of bit 7.
- R4: Subtract writes (A - T) mod 256 and subtract with borrow writes (A - T - cy_in) mod 256. For both, CY is 1 exactly when a borrow occurs, that is, when the true difference is negative.
- R5: Compare sets every flag exactly as subtract would, and leaves the accumulator unchanged.
- R6: AND, OR and XOR write the bitwise result and clear CY. AC becomes 1 after AND and 0 after OR or XOR.
- R7: Increment writes (A + 1) mod 256 and decrement writes (A - 1) mod 256. Both ignore the temporary operand and leave CY at its previous value.
- R8: S equals bit 7 of the result. Z is 1 when the result is 0x00 and 0 otherwise.
- R9: P is 1 when the result has an even number of ones, and 0 when the count is odd.
- R10: For arithmetic operations, AC is the carry out of bit 3 of the internal addition. That addition is A + T + c for add, A + ~T + 1 for subtract and compare, A + ~T + (1 - cy_in) for subtract with borrow, A + 1 for increment, and A + 0xFF for decrement. Decrement therefore sets AC exactly when the low nibble of A is nonzero.
- R11: The flag byte holds S in bit 7, Z in bit 6, AC in bit 4, P in bit 2 and CY in bit 0. Bit 1 always reads 1, and bits 5 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe; registers update only when high |
| op_sel | input | 4 | Operation code (see R3) |
| tmp_in | input | DATA_W | Temporary (second) operand |
| cy_in | input | 1 | Carry/borrow input, normally the caller's copy of flag bit 0 |
| acc_out | output | DATA_W | Registered accumulator |
| flags_out | output | 8 | Registered flag byte |

## Verification
Two cases are hard to reach from the ports. The first is the rule that increment and decrement preserve CY when CY is 1. The second is the half-carry produced by the inverted operand on subtract-with-borrow. In both cases the accumulator and CY must first be steered into a specific state by earlier operations. The stimulus table is therefore a single chained sequence from reset. An add that overflows sets CY to 1, and an increment and a decrement then follow while CY is still set. Each borrow case is placed so that its low nibbles produce a known AC. Compare is run both with and without borrow between two writes, so the unchanged accumulator is visible in the next result.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_INR = 4'd8,
    OP_DCR = 4'd9
  } alu_op_e;

  // second adder operand source
  typedef enum logic [1:0] {
    BSEL_TMP  = 2'd0,
    BSEL_NTMP = 2'd1,
    BSEL_ZERO = 2'd2,
    BSEL_ONES = 2'd3
  } bsel_e;

  // adder carry-in source
  typedef enum logic [1:0] {
    CSEL_ZERO = 2'd0,
    CSEL_ONE  = 2'd1,
    CSEL_CIN  = 2'd2,
    CSEL_NCIN = 2'd3
  } csel_e;

  typedef enum logic [1:0] {
    LSEL_AND = 2'd0,
    LSEL_XOR = 2'd1,
    LSEL_OR  = 2'd2
  } lsel_e;

  typedef struct packed {
    logic  valid;
    logic  arith;
    logic  write_acc;
    bsel_e bsel;
    csel_e csel;
    logic  borrow;
    logic  keep_cy;
    lsel_e lsel;
    logic  ac_logic;
  } alu_ctl_t;

  localparam int FLAG_W   = 8;
  localparam int FB_S     = 7;
  localparam int FB_Z     = 6;
  localparam int FB_AC    = 4;
  localparam int FB_P     = 2;
  localparam int FB_ONE   = 1;
  localparam int FB_CY    = 0;

  function automatic logic [FLAG_W-1:0] pack_flags(input logic s, input logic z,
                                                   input logic ac, input logic p,
                                                   input logic cy);
    logic [FLAG_W-1:0] f;
    f         = '0;
    f[FB_S]   = s;
    f[FB_Z]   = z;
    f[FB_AC]  = ac;
    f[FB_P]   = p;
    f[FB_ONE] = 1'b1;
    f[FB_CY]  = cy;
    return f;
  endfunction

  localparam logic [FLAG_W-1:0] FLAGS_RST = pack_flags(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

endpackage

// File: rtl/alu8_opdec.sv
module alu8_opdec
  import alu8_pkg::*;
(
  input  logic [3:0] op_sel,
  output alu_ctl_t   ctl
);

  always_comb begin
    ctl           = '0;
    ctl.valid     = 1'b1;
    ctl.arith     = 1'b1;
    ctl.write_acc = 1'b1;
    ctl.bsel      = BSEL_TMP;
    ctl.csel      = CSEL_ZERO;
    ctl.lsel      = LSEL_AND;
    unique case (op_sel)
      OP_ADD: ;
      OP_ADC: ctl.csel = CSEL_CIN;
      OP_SUB: begin
        ctl.bsel   = BSEL_NTMP;
        ctl.csel   = CSEL_ONE;
        ctl.borrow = 1'b1;
      end
      OP_SBB: begin
        ctl.bsel   = BSEL_NTMP;
        ctl.csel   = CSEL_NCIN;
        ctl.borrow = 1'b1;
      end
      OP_CMP: begin
        ctl.bsel      = BSEL_NTMP;
        ctl.csel      = CSEL_ONE;
        ctl.borrow    = 1'b1;
        ctl.write_acc = 1'b0;
      end
      OP_INR: begin
        ctl.bsel    = BSEL_ZERO;
        ctl.csel    = CSEL_ONE;
        ctl.keep_cy = 1'b1;
      end
      OP_DCR: begin
        ctl.bsel    = BSEL_ONES;
        ctl.keep_cy = 1'b1;
      end
      OP_AND: begin
        ctl.arith    = 1'b0;
        ctl.lsel     = LSEL_AND;
        ctl.ac_logic = 1'b1;
      end
      OP_XOR: begin
        ctl.arith = 1'b0;
        ctl.lsel  = LSEL_XOR;
      end
      OP_OR: begin
        ctl.arith = 1'b0;
        ctl.lsel  = LSEL_OR;
      end
      default: begin
        ctl.valid     = 1'b0;
        ctl.write_acc = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              c_in,
  output logic [DATA_W-1:0] sum,
  output logic              c_out,
  output logic              c_nib
);

  localparam int HI_W = DATA_W - NIB_W;

  logic [NIB_W:0] lo_sum;
  logic [HI_W:0]  hi_sum;

  // split adder exposes the half carry between the two sections
  always_comb begin
    lo_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_in};
    hi_sum = {1'b0, a[DATA_W-1:NIB_W]} + {1'b0, b[DATA_W-1:NIB_W]}
           + {{HI_W{1'b0}}, lo_sum[NIB_W]};
  end

  assign sum   = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
  assign c_out = hi_sum[HI_W];
  assign c_nib = lo_sum[NIB_W];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  lsel_e             lsel,
  output logic [DATA_W-1:0] res
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      unique case (lsel)
        LSEL_XOR: res[i] = a[i] ^ b[i];
        LSEL_OR:  res[i] = a[i] | b[i];
        default:  res[i] = a[i] & b[i];
      endcase
    end
  end

endmodule

// File: rtl/alu8_flagpack.sv
module alu8_flagpack
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              cy,
  input  logic              ac,
  output logic [FLAG_W-1:0] flags
);

  logic s_bit, z_bit, p_bit;

  assign s_bit = res[DATA_W-1];
  assign z_bit = ~|res;
  assign p_bit = ~^res;
  assign flags = pack_flags(s_bit, z_bit, ac, p_bit, cy);

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_en,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] tmp_in,
  input  logic              cy_in,
  output logic [DATA_W-1:0] acc_out,
  output logic [FLAG_W-1:0] flags_out
);

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] acc_q;
  logic [FLAG_W-1:0] flag_q;
  logic [DATA_W-1:0] b_eff, add_sum, log_res, result;
  logic              c_eff, add_cout, add_cnib;
  logic              cy_new, ac_new;
  logic [FLAG_W-1:0] flag_new;

  alu8_opdec u_dec (
    .op_sel (op_sel),
    .ctl    (ctl)
  );

  always_comb begin
    unique case (ctl.bsel)
      BSEL_NTMP: b_eff = ~tmp_in;
      BSEL_ZERO: b_eff = '0;
      BSEL_ONES: b_eff = '1;
      default:   b_eff = tmp_in;
    endcase
    unique case (ctl.csel)
      CSEL_ONE:  c_eff = 1'b1;
      CSEL_CIN:  c_eff = cy_in;
      CSEL_NCIN: c_eff = ~cy_in;
      default:   c_eff = 1'b0;
    endcase
  end

  alu8_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_add (
    .a     (acc_q),
    .b     (b_eff),
    .c_in  (c_eff),
    .sum   (add_sum),
    .c_out (add_cout),
    .c_nib (add_cnib)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_log (
    .a    (acc_q),
    .b    (tmp_in),
    .lsel (ctl.lsel),
    .res  (log_res)
  );

  always_comb begin
    result = ctl.arith ? add_sum : log_res;
    if (ctl.keep_cy)    cy_new = flag_q[FB_CY];
    else if (ctl.arith) cy_new = add_cout ^ ctl.borrow;
    else                cy_new = 1'b0;
    ac_new = ctl.arith ? add_cnib : ctl.ac_logic;
  end

  alu8_flagpack #(.DATA_W(DATA_W)) u_flg (
    .res   (result),
    .cy    (cy_new),
    .ac    (ac_new),
    .flags (flag_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      flag_q <= FLAGS_RST;
    end else if (exec_en && ctl.valid) begin
      if (ctl.write_acc) acc_q <= result;
      flag_q <= flag_new;
    end
  end

  assign acc_out   = acc_q;
  assign flags_out = flag_q;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              exec_en,
  input logic [3:0]        op_sel,
  input logic [DATA_W-1:0] acc_out,
  input logic [FLAG_W-1:0] flags_out
);

  logic op_ok, op_logic, op_step;
  assign op_ok    = (op_sel <= 4'd9);
  assign op_logic = (op_sel == OP_AND) || (op_sel == OP_OR) || (op_sel == OP_XOR);
  assign op_step  = (op_sel == OP_INR) || (op_sel == OP_DCR);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (acc_out == '0) && (flags_out == 8'h02)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(exec_en && op_ok) |=> $stable(acc_out) && $stable(flags_out)); // R2

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel == OP_CMP) |=> $stable(acc_out)); // R5

  AST_LOGIC_CLEARS_CY: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_logic) |=> !flags_out[FB_CY]); // R6

  AST_STEP_KEEPS_CY: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_step) |=> flags_out[FB_CY] == $past(flags_out[FB_CY])); // R7

  AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_ok && op_sel != OP_CMP) |=>
      (flags_out[FB_S] == acc_out[DATA_W-1]) && (flags_out[FB_Z] == (acc_out == '0))); // R8

  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_ok && op_sel != OP_CMP) |=> flags_out[FB_P] == ~^acc_out); // R9

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> flags_out[1] && !flags_out[3] && !flags_out[5]); // R11

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .exec_en   (exec_en),
  .op_sel    (op_sel),
  .acc_out   (acc_out),
  .flags_out (flags_out)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_en = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] tmp_in = 8'h00;
  logic       cy_in = 1'b0;
  logic [7:0] acc_out;
  logic [7:0] flags_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  alu8_core u_alu8_core (
    .clk       (clk),
    .rst       (rst),
    .exec_en   (exec_en),
    .op_sel    (op_sel),
    .tmp_in    (tmp_in),
    .cy_in     (cy_in),
    .acc_out   (acc_out),
    .flags_out (flags_out)
  );

  // {op, tmp, cy_in, expected acc, expected flags}; chained from reset
  localparam logic [28:0] VEC [0:18] = '{
    {4'd0, 8'h3A, 1'b0, 8'h3A, 8'h06},
    {4'd0, 8'hC6, 1'b0, 8'h00, 8'h57},
    {4'd1, 8'h0F, 1'b1, 8'h10, 8'h12},
    {4'd2, 8'h20, 1'b0, 8'hF0, 8'h97},
    {4'd3, 8'h0F, 1'b1, 8'hE0, 8'h82},
    {4'd7, 8'hE0, 1'b0, 8'hE0, 8'h56},
    {4'd7, 8'hF1, 1'b0, 8'hE0, 8'h83},
    {4'd4, 8'h3C, 1'b0, 8'h20, 8'h12},
    {4'd6, 8'h81, 1'b0, 8'hA1, 8'h82},
    {4'd5, 8'hA1, 1'b0, 8'h00, 8'h46},
    {4'd9, 8'h00, 1'b0, 8'hFF, 8'h86},
    {4'd8, 8'h00, 1'b0, 8'h00, 8'h56},
    {4'd5, 8'h7F, 1'b0, 8'h7F, 8'h02},
    {4'd8, 8'h5A, 1'b1, 8'h80, 8'h92},
    {4'd0, 8'h80, 1'b0, 8'h00, 8'h47},
    {4'd8, 8'h00, 1'b0, 8'h01, 8'h03},
    {4'd9, 8'hC3, 1'b0, 8'h00, 8'h57},
    {4'd3, 8'h00, 1'b1, 8'hFF, 8'h87},
    {4'd1, 8'h00, 1'b1, 8'h00, 8'h57}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic [3:0] op, input logic [7:0] t, input logic c, input logic en);
    op_sel  = op;
    tmp_in  = t;
    cy_in   = c;
    exec_en = en;
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R3 add";
      4'd2, 4'd3: return "R4 sub";
      4'd7:       return "R5 cmp";
      4'd4, 4'd5, 4'd6: return "R6 logic";
      default:    return "R7 step";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset acc", acc_out, 8'h00);
    chk("R1 reset flags", flags_out, 8'h02);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 19; i++) begin
      step(VEC[i][28:25], VEC[i][24:17], VEC[i][16], 1'b1);
      chk({tag_of(VEC[i][28:25]), " acc"}, acc_out, VEC[i][15:8]);
      chk({tag_of(VEC[i][28:25]), " flags R8/R9/R10/R11"}, flags_out, VEC[i][7:0]);
    end

    // load a known value: 00 + 55 -> 55, even parity
    step(4'd0, 8'h55, 1'b0, 1'b1);
    chk("R3 load acc", acc_out, 8'h55);
    chk("R9 load flags", flags_out, 8'h06);

    // strobe low: a subtract must have no effect
    step(4'd2, 8'h11, 1'b1, 1'b0);
    chk("R2 idle acc", acc_out, 8'h55);
    chk("R2 idle flags", flags_out, 8'h06);

    // undefined codes with strobe high: no effect
    for (int k = 10; k < 16; k++) begin
      step(4'(k), 8'hFF, 1'b1, 1'b1);
      chk("R2 undefined code acc", acc_out, 8'h55);
      chk("R2 undefined code flags", flags_out, 8'h06);
    end

    // AND with zero result: Z, P, AC set, CY clear
    step(4'd4, 8'hAA, 1'b1, 1'b1);
    chk("R6 and-zero acc", acc_out, 8'h00);
    chk("R6 and-zero flags", flags_out, 8'h56);

    // mid-run reset
    step(4'd9, 8'h00, 1'b0, 1'b1);
    chk("R7 dcr acc", acc_out, 8'hFF);
    exec_en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset acc", acc_out, 8'h00);
    chk("R1 mid reset flags", flags_out, 8'h02);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule